// File: doc/BRIEF.md
# Warp Branch Mask Sequencer

This block steers the active-lane mask of one 32-lane warp through two-way branches under lock-step issue. A one-cycle branch strobe supplies a predicate bit per lane and three instruction counts: the length of the taken path, the length of the not-taken path and the length of the shared tail that follows both. The sequencer issues the taken path with the lanes whose predicate is set, then the not-taken path with the remaining lanes, and then the tail with the full mask that was live at the branch. One instruction occupies one issue cycle. A path with no live lane or a length of zero is skipped and costs no cycle.

A strobe that arrives while a branch is running opens a nested branch. Its entry mask is the mask being issued in that cycle. The unfinished outer branch waits on a small save stack and resumes where it stopped once the inner branch has drained. Two running totals, one of issued cycles and one of active lane-cycles, let lane utilization be formed as lane-cycles divided by 32 times issued cycles. That ratio depends only on how many lanes each path holds, not on which lanes they are.

Top module: `simt_div_seq`

## Requirements
- R1: After reset `issue_valid` is 0, `issue_cycles` and `lane_cycles` are 0 and `stack_ovf` is 0.
- R2: A branch strobe accepted while idle uses `warp_mask` as the entry mask. From the cycle after the strobe edge, the taken path is issued for `len_taken` cycles with `issue_mask` = entry AND `br_pred`.
- R3: After the taken path, the not-taken path is issued for `len_not` cycles with entry AND NOT `br_pred`. The tail is then issued for `len_tail` cycles with the entry mask, after which `issue_valid` returns to 0.
- R4: A path whose mask is all zeros, or whose length is 0, is skipped and takes no issue cycle. The next live path begins at once.
- R5: `issue_cycles` rises by one for each cycle with `issue_valid` = 1. `lane_cycles` rises by the number of set bits of `issue_mask` in that cycle. A 16/16 split with lengths 20, 12 and 8 gives 40 and 768.
- R6: An interleaved predicate (even lanes set) and a contiguous predicate (lower 16 lanes set) with equal lengths give identical `issue_cycles` and `lane_cycles`.
- R7: A strobe accepted while issuing starts a nested branch whose entry mask is the current `issue_mask`, and `warp_mask` is ignored. The outer branch is suspended after its issue in that cycle and resumes with its remaining count once the inner branch ends.
- R8: The save stack holds `STK_DEPTH` suspended branches. A strobe that would need a push while the stack is full is ignored and sets `stack_ovf`, which stays 1 until reset.
- R9: A strobe while idle whose entry mask is zero, or whose three paths are all empty, issues nothing and leaves both counters unchanged.
- R10: A strobe while busy whose three paths are all empty has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| br_start | input | 1 | Branch strobe, one cycle |
| warp_mask | input | 32 | Entry mask for a branch started while idle |
| br_pred | input | 32 | Per-lane branch predicate, 1 = taken |
| len_taken | input | 8 | Taken-path length in instructions |
| len_not | input | 8 | Not-taken-path length in instructions |
| len_tail | input | 8 | Shared tail length in instructions |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_mask | output | 32 | Active lanes of the issued instruction |
| issue_cycles | output | 32 | Running count of issued cycles |
| lane_cycles | output | 32 | Running sum of active lanes over issued cycles |
| stack_ovf | output | 1 | Sticky flag: a nested branch was dropped on a full stack |

## Verification
The bench builds the block with `STK_DEPTH` = 2. Three nested strobes are then enough to overflow the stack, and the dropped branch shows up as a mask that never appears on `issue_mask`. With the default statistic width of 32 and default lengths, the 20/12/8 split can be checked to the exact lane-cycle total of 768. Even/odd and lower/upper splits are run from reset so that the totals can be compared directly. Nested and empty strobes are placed in the middle of taken and not-taken paths, which shows whether the suspended count resumes exactly.

// File: rtl/simt_pkg.sv
package simt_pkg;

  localparam int LANES = 32;
  localparam int CNT_W = 8;

  typedef logic [LANES-1:0] mask_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_TAKEN = 2'd0,
    PH_NOT   = 2'd1,
    PH_TAIL  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  typedef struct packed {
    mask_t  entry;
    mask_t  tmask;
    mask_t  nmask;
    cnt_t   tlen;
    cnt_t   nlen;
    cnt_t   klen;
    cnt_t   rem;
    phase_e phase;
  } frame_t;

  function automatic frame_t idle_frame();
    frame_t r;
    r = '0;
    r.phase = PH_DONE;
    return r;
  endfunction

  function automatic phase_e phase_after(phase_e p);
    phase_e r;
    case (p)
      PH_TAKEN: r = PH_NOT;
      PH_NOT:   r = PH_TAIL;
      default:  r = PH_DONE;
    endcase
    return r;
  endfunction

  // Enter phase p, or the first later phase that has live lanes and a length.
  function automatic frame_t enter_phase(frame_t f, phase_e p);
    frame_t r;
    r = f;
    r.phase = PH_DONE;
    r.rem = '0;
    if (p == PH_TAKEN && f.tmask != '0 && f.tlen != '0) begin
      r.phase = PH_TAKEN;
      r.rem = f.tlen;
    end else if ((p == PH_TAKEN || p == PH_NOT) && f.nmask != '0 && f.nlen != '0) begin
      r.phase = PH_NOT;
      r.rem = f.nlen;
    end else if (p != PH_DONE && f.entry != '0 && f.klen != '0) begin
      r.phase = PH_TAIL;
      r.rem = f.klen;
    end
    return r;
  endfunction

  function automatic mask_t phase_mask(frame_t f);
    mask_t m;
    case (f.phase)
      PH_TAKEN: m = f.tmask;
      PH_NOT:   m = f.nmask;
      PH_TAIL:  m = f.entry;
      default:  m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/simt_popcnt.sv
module simt_popcnt #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/simt_frame_load.sv
module simt_frame_load
  import simt_pkg::*;
(
  input  mask_t  entry,
  input  mask_t  pred,
  input  cnt_t   tlen,
  input  cnt_t   nlen,
  input  cnt_t   klen,
  output frame_t frame,
  output logic   live
);

  frame_t raw;

  always_comb begin
    raw       = idle_frame();
    raw.entry = entry;
    raw.tmask = entry & pred;
    raw.nmask = entry & ~pred;
    raw.tlen  = tlen;
    raw.nlen  = nlen;
    raw.klen  = klen;
    frame     = enter_phase(raw, PH_TAKEN);
    live      = (frame.phase != PH_DONE);
  end

endmodule

// File: rtl/simt_frame_step.sv
module simt_frame_step
  import simt_pkg::*;
(
  input  frame_t cur,
  output frame_t nxt
);

  always_comb begin
    nxt = cur;
    if (cur.phase != PH_DONE) begin
      if (cur.rem > cnt_t'(1)) begin
        nxt.rem = cur.rem - cnt_t'(1);
      end else begin
        nxt = enter_phase(cur, phase_after(cur.phase));
      end
    end
  end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  logic   pop,
  input  frame_t din,
  output frame_t dout,
  output logic   empty,
  output logic   full
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  frame_t        mem [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;

  assign empty  = (ptr_q == '0);
  assign full   = (ptr_q == PW'(DEPTH));
  assign wr_idx = IW'(ptr_q);
  assign rd_idx = IW'(ptr_q - PW'(1));
  assign dout   = empty ? idle_frame() : mem[rd_idx];
  assign ptr_en = push | pop;

  always_comb begin
    ptr_d = ptr_q;
    if (push)     ptr_d = ptr_q + PW'(1);
    else if (pop) ptr_d = ptr_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_idx == IW'(g)) mem[g] <= din;
    end
  end

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R7
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  // R7
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/simt_div_seq.sv
module simt_div_seq
  import simt_pkg::*;
#(
  parameter int STK_DEPTH = 4,
  parameter int STAT_W    = 32,
  localparam int PC_W     = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_start,
  input  logic [LANES-1:0]  warp_mask,
  input  logic [LANES-1:0]  br_pred,
  input  logic [CNT_W-1:0]  len_taken,
  input  logic [CNT_W-1:0]  len_not,
  input  logic [CNT_W-1:0]  len_tail,
  output logic              issue_valid,
  output logic [LANES-1:0]  issue_mask,
  output logic [STAT_W-1:0] issue_cycles,
  output logic [STAT_W-1:0] lane_cycles,
  output logic              stack_ovf
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  frame_t act_q, act_d;
  frame_t step_f, new_f, ret_f, stk_top;
  logic   new_live, ret_live, idle, act_en;
  logic   push, pop, stk_empty, stk_full;
  logic   ovf_q, ovf_d, ovf_en;
  mask_t  entry_sel;
  logic [PC_W-1:0]   lanes_now;
  logic [STAT_W-1:0] icyc_q, icyc_d, lcyc_q, lcyc_d;

  assign idle        = (act_q.phase == PH_DONE);
  assign issue_valid = !idle;
  assign issue_mask  = phase_mask(act_q);
  assign entry_sel   = idle ? warp_mask : issue_mask;

  simt_frame_load u_load (
    .entry (entry_sel),
    .pred  (br_pred),
    .tlen  (len_taken),
    .nlen  (len_not),
    .klen  (len_tail),
    .frame (new_f),
    .live  (new_live)
  );

  simt_frame_step u_step (
    .cur (act_q),
    .nxt (step_f)
  );

  simt_recon_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_ns),
    .push  (push),
    .pop   (pop),
    .din   (ret_f),
    .dout  (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  simt_popcnt #(.W(LANES)) u_pop (
    .vec (issue_mask),
    .cnt (lanes_now)
  );

  // next-state: frame sequencing
  always_comb begin
    ret_f    = idle ? act_q : step_f;
    ret_live = (ret_f.phase != PH_DONE);
    act_d    = ret_f;
    push     = 1'b0;
    pop      = 1'b0;
    ovf_d    = ovf_q;
    if (br_start && new_live) begin
      if (ret_live) begin
        if (stk_full) begin
          ovf_d = 1'b1;
        end else begin
          push  = 1'b1;
          act_d = new_f;
        end
      end else begin
        act_d = new_f;
      end
    end else if (!ret_live && !stk_empty) begin
      pop   = 1'b1;
      act_d = stk_top;
    end
  end

  assign act_en = !idle || br_start;
  assign ovf_en = br_start && !ovf_q;

  // next-state: statistics
  always_comb begin
    icyc_d = icyc_q + STAT_W'(1);
    lcyc_d = lcyc_q + STAT_W'(lanes_now);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     act_q <= idle_frame();
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      icyc_q <= '0;
      lcyc_q <= '0;
    end else if (issue_valid) begin
      icyc_q <= icyc_d;
      lcyc_q <= lcyc_d;
    end
  end

  assign issue_cycles = icyc_q;
  assign lane_cycles  = lcyc_q;
  assign stack_ovf    = ovf_q;

  // R4
  no_empty_issue_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    issue_valid |-> (issue_mask != '0));

  // R5
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    issue_valid |=> (lane_cycles - $past(lane_cycles)) == STAT_W'($countones($past(issue_mask))));

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !issue_valid |=> ($stable(issue_cycles) && $stable(lane_cycles)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    stack_ovf |=> stack_ovf);

  // R7
  nest_live_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !stk_empty |-> issue_valid);

endmodule

// File: tb/simt_div_seq_bench.sv
module simt_div_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LN = 32;

  logic          clk;
  logic          rst_n;
  logic          br_start;
  logic [LN-1:0] warp_mask;
  logic [LN-1:0] br_pred;
  logic [7:0]    len_taken, len_not, len_tail;
  logic          issue_valid;
  logic [LN-1:0] issue_mask;
  logic [31:0]   issue_cycles, lane_cycles;
  logic          stack_ovf;

  int n_vec = 0;
  int n_err = 0;

  simt_div_seq #(.STK_DEPTH(2), .STAT_W(32)) u_simt_div_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_start     (br_start),
    .warp_mask    (warp_mask),
    .br_pred      (br_pred),
    .len_taken    (len_taken),
    .len_not      (len_not),
    .len_tail     (len_tail),
    .issue_valid  (issue_valid),
    .issue_mask   (issue_mask),
    .issue_cycles (issue_cycles),
    .lane_cycles  (lane_cycles),
    .stack_ovf    (stack_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    br_start = 1'b0;
    warp_mask = '0;
    br_pred = '0;
    len_taken = '0;
    len_not = '0;
    len_tail = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_br(input logic [LN-1:0] wm, input logic [LN-1:0] pr,
                          input int lt, input int ln, input int lk);
    warp_mask = wm;
    br_pred = pr;
    len_taken = 8'(lt);
    len_not = 8'(ln);
    len_tail = 8'(lk);
    br_start = 1'b1;
    @(negedge clk);
    br_start = 1'b0;
  endtask

  task automatic expect_run(input logic [LN-1:0] m, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, 64'(issue_valid), 64'd1);
      check(req, 64'(issue_mask), 64'(m));
      @(negedge clk);
    end
  endtask

  task automatic expect_idle(input string req);
    check(req, 64'(issue_valid), 64'd0);
  endtask

  task automatic expect_stats(input int cyc, input int lanes, input string req);
    check(req, 64'(issue_cycles), 64'(cyc));
    check(req, 64'(lane_cycles), 64'(lanes));
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    expect_idle("R1");
    expect_stats(0, 0, "R1");
    check("R1", 64'(stack_ovf), 64'd0);
  endtask

  // R2 R3 R5: interleaved even/odd split
  task automatic t_interleave();
    do_reset();
    start_br(32'hFFFF_FFFF, 32'h5555_5555, 20, 12, 8);
    expect_run(32'h5555_5555, 20, "R2");
    expect_run(32'hAAAA_AAAA, 12, "R3");
    expect_run(32'hFFFF_FFFF, 8, "R3");
    expect_idle("R3");
    expect_stats(40, 768, "R5");
  endtask

  // R6: contiguous lower/upper split gives the same totals
  task automatic t_contig();
    do_reset();
    start_br(32'hFFFF_FFFF, 32'h0000_FFFF, 20, 12, 8);
    expect_run(32'h0000_FFFF, 20, "R6");
    expect_run(32'hFFFF_0000, 12, "R6");
    expect_run(32'hFFFF_FFFF, 8, "R6");
    expect_idle("R6");
    expect_stats(40, 768, "R6");
  endtask

  // R4 R9: skipped paths and empty branches
  task automatic t_skip();
    do_reset();
    start_br(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 5, 2);
    expect_run(32'hFFFF_FFFF, 3, "R4");
    expect_run(32'hFFFF_FFFF, 2, "R4");
    expect_idle("R4");
    start_br(32'h0000_00F0, 32'h0000_0000, 4, 2, 1);
    expect_run(32'h0000_00F0, 2, "R4");
    expect_run(32'h0000_00F0, 1, "R4");
    expect_idle("R4");
    start_br(32'h0000_FFFF, 32'h0000_000F, 0, 3, 0);
    expect_run(32'h0000_FFF0, 3, "R4");
    expect_idle("R4");
    start_br(32'h0000_0000, 32'h0000_FFFF, 3, 3, 3);
    expect_idle("R9");
    @(negedge clk);
    expect_idle("R9");
    expect_stats(11, 208, "R9");
  endtask

  // R7 R10: nested branch and an empty strobe while busy
  task automatic t_nested();
    do_reset();
    start_br(32'hFFFF_FFFF, 32'h0000_FFFF, 4, 3, 2);
    expect_run(32'h0000_FFFF, 1, "R7");
    check("R7", 64'(issue_mask), 64'h0000_FFFF);
    start_br(32'h0000_0000, 32'h0000_00FF, 2, 1, 1);
    expect_run(32'h0000_00FF, 2, "R7");
    expect_run(32'h0000_FF00, 1, "R7");
    expect_run(32'h0000_FFFF, 1, "R7");
    expect_run(32'h0000_FFFF, 2, "R7");
    check("R10", 64'(issue_mask), 64'hFFFF_0000);
    start_br(32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 0);
    expect_run(32'hFFFF_0000, 2, "R10");
    expect_run(32'hFFFF_FFFF, 2, "R10");
    expect_idle("R10");
    expect_stats(13, 216, "R7");
  endtask

  // R8: overflow on a stack of two
  task automatic t_overflow();
    do_reset();
    start_br(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5, 0, 0);
    check("R8", 64'(issue_mask), 64'hFFFF_FFFF);
    start_br(32'h0000_0000, 32'h0000_FFFF, 3, 0, 0);
    check("R8", 64'(issue_mask), 64'h0000_FFFF);
    start_br(32'h0000_0000, 32'h0000_00FF, 3, 0, 0);
    check("R8", 64'(issue_mask), 64'h0000_00FF);
    check("R8", 64'(stack_ovf), 64'd0);
    start_br(32'h0000_0000, 32'h0000_000F, 3, 0, 0);
    check("R8", 64'(stack_ovf), 64'd1);
    expect_run(32'h0000_00FF, 2, "R8");
    expect_run(32'h0000_FFFF, 2, "R8");
    expect_run(32'hFFFF_FFFF, 4, "R8");
    expect_idle("R8");
    check("R8", 64'(stack_ovf), 64'd1);
    expect_stats(11, 232, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_interleave();
    t_contig();
    t_skip();
    t_nested();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule